// File: doc/BRIEF.md
# Variation-Aware Issue Queue Allocator

This block is a small non-collapsing instruction issue queue for an out-of-order core whose storage entries do not all meet the same timing. A test-time characterisation marks some entries as slow. The resulting bit vector is loaded through a configuration port. When an instruction is dispatched, the allocator places it in a free fast entry if one exists. It uses a slow entry only when no fast entry is free. A write into a slow entry takes one extra cycle, and dispatch stalls during that cycle.

Each entry holds an opcode, two source tags with their ready flags, and a destination tag. A result broadcast carries a destination tag, and any waiting source operand with the same tag becomes ready. The same broadcast also applies to an instruction being written in that cycle. Each cycle, the lowest-index entry with both operands ready is presented on the issue output and is freed at the next clock edge. Entries never move after allocation, so the index reported at issue is the index chosen at dispatch.

Top module: `viq_top`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty, `iss_valid`, `disp_stall` and `q_full` are 0, and every entry is treated as fast (the slow vector is all zeros).
- R2: An accepted dispatch (`disp_valid` high while `disp_stall` is low at a rising edge) is placed in the lowest-index free entry whose slow bit is 0.
- R3: A slow entry (slow bit 1) is used only when no fast entry is free, and the allocator then picks the lowest-index free slow entry.
- R4: A write into a fast entry completes at the accepting edge. If both operands are ready, the instruction is on the issue output in the cycle that follows, and `disp_stall` is not raised by the write.
- R5: A write into a slow entry raises `disp_stall` for exactly the one cycle after the accepting edge. The entry becomes visible to select one cycle later than a fast write would.
- R6: A broadcast (`wb_valid` with `wb_tag`) sets the ready flag of every waiting source whose tag matches. This includes an instruction dispatched in the same cycle and an instruction in its extra slow-write cycle.
- R7: At most one instruction issues per cycle. The issued entry is the lowest-index entry that is valid with both sources ready, and it is freed at the next edge.
- R8: When every entry is valid, `q_full` and `disp_stall` are 1, and a dispatch request offered then is not accepted.
- R9: Entries never move. `iss_idx` equals the index assigned at dispatch, whatever order the instructions wake up in.
- R10: A pulse on `cfg_load` replaces the slow vector with `cfg_slow` (bit i marks entry i slow). The new vector governs every later allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the slow-entry vector |
| cfg_slow | input | DEPTH | Slow-entry vector, bit i for entry i |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_src0 | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_stall | output | 1 | Dispatch not accepted this cycle |
| q_full | output | 1 | Every entry is occupied |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Broadcast destination tag |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_idx | output | $clog2(DEPTH) | Entry index of the issuing instruction |
| iss_op | output | OP_W | Opcode of the issuing instruction |
| iss_src0 | output | TAG_W | First source tag of the issuing instruction |
| iss_src1 | output | TAG_W | Second source tag of the issuing instruction |
| iss_dst | output | TAG_W | Destination tag of the issuing instruction |

## Verification
The bench builds the queue with DEPTH=4, TAG_W=5 and OP_W=6. With only four entries, a few dispatches reach the full condition. A mixed slow vector such as 0101 then forces the fallback from fast to slow entries within a short sequence. With this depth, one shared wakeup tag can make every entry ready at once, so lowest-index select is exercised across the whole queue. Wakeups delivered in an order different from allocation show that entry indices stay fixed. Broadcasts timed to land on the dispatch cycle and on the extra slow-write cycle cover the two bypass paths.

// File: rtl/viq_pkg.sv
// Package: shared types for the variation-aware issue queue.
// Holds the dispatch write-state encoding used by the top level.
package viq_pkg;

    // State of the dispatch write path: idle, or finishing a slow-entry write.
    typedef enum logic {
        WR_IDLE      = 1'b0,
        WR_SLOW_DONE = 1'b1
    } wr_state_e;

endpackage

// File: rtl/viq_pick.sv
// Module: viq_pick
// Lowest-index priority picker. It returns the index of the lowest set
// request bit and a found flag.
// Assumes: W >= 2. The index is meaningless when found is 0.
module viq_pick #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan upward and keep the first request seen.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (!found && req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/viq_alloc.sv
// Module: viq_alloc
// Allocation decoder. It prefers the lowest free fast entry. When no fast
// entry is free, it falls back to the lowest free slow entry.
// Assumes: free and slow are both indexed by entry number.
module viq_alloc #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] free_vec,
    input  logic [DEPTH-1:0] slow_vec,
    output logic             found,
    output logic [IW-1:0]    idx,
    output logic             is_slow
);

    logic [DEPTH-1:0] fast_free;
    logic [DEPTH-1:0] slow_free;
    logic             fast_found;
    logic             slow_found;
    logic [IW-1:0]    fast_idx;
    logic [IW-1:0]    slow_idx;

    // Split the free set by the speed class of each entry.
    always_comb begin
        fast_free = free_vec & ~slow_vec;
        slow_free = free_vec & slow_vec;
    end

    viq_pick #(.W(DEPTH)) u_fast (.req(fast_free), .found(fast_found), .idx(fast_idx));
    viq_pick #(.W(DEPTH)) u_slow (.req(slow_free), .found(slow_found), .idx(slow_idx));

    // Fast entries win. A slow entry is chosen only as a fallback.
    always_comb begin
        found   = fast_found | slow_found;
        is_slow = !fast_found && slow_found;
        idx     = fast_found ? fast_idx : slow_idx;
    end

endmodule

// File: rtl/viq_select.sv
// Module: viq_select
// Issue select. It grants the lowest-index entry whose operands are both
// ready, at most one per cycle, and returns the grant as one-hot and index.
// Assumes: ready_vec already includes the valid bit.
module viq_select #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ready_vec,
    output logic             found,
    output logic [IW-1:0]    idx,
    output logic [DEPTH-1:0] grant
);

    viq_pick #(.W(DEPTH)) u_pick (.req(ready_vec), .found(found), .idx(idx));

    // Decode the chosen index into a one-hot grant.
    always_comb begin
        grant = '0;
        if (found) grant[idx] = 1'b1;
    end

    // R7: never more than one entry is granted, and only a ready one.
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~ready_vec) == '0));

endmodule

// File: rtl/viq_entry.sv
// Module: viq_entry
// One issue-queue slot: a valid bit, an opcode, two source tags with ready
// flags, and a destination tag. It is loaded by a write, woken by a tag
// broadcast, and freed by an issue.
// Assumes: wr_en only targets a free slot. The write data already carries
// any same-cycle wakeup.
module viq_entry #(
    parameter int TAG_W = 6,
    parameter int OP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OP_W-1:0]  wr_op,
    input  logic [TAG_W-1:0] wr_s0,
    input  logic             wr_r0,
    input  logic [TAG_W-1:0] wr_s1,
    input  logic             wr_r1,
    input  logic [TAG_W-1:0] wr_dst,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             iss_clr,
    output logic             valid,
    output logic             rdy,
    output logic [OP_W-1:0]  op,
    output logic [TAG_W-1:0] s0,
    output logic [TAG_W-1:0] s1,
    output logic [TAG_W-1:0] dst
);

    logic r0;
    logic r1;

    // Slot state: load on write, clear on issue, set ready flags on a tag match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            r0    <= 1'b0;
            r1    <= 1'b0;
            op    <= '0;
            s0    <= '0;
            s1    <= '0;
            dst   <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            op    <= wr_op;
            s0    <= wr_s0;
            r0    <= wr_r0;
            s1    <= wr_s1;
            r1    <= wr_r1;
            dst   <= wr_dst;
        end else if (iss_clr) begin
            valid <= 1'b0;
        end else if (valid && wb_valid) begin
            if (wb_tag == s0) r0 <= 1'b1;
            if (wb_tag == s1) r1 <= 1'b1;
        end
    end

    // The slot can be selected when it is occupied and both operands are ready.
    always_comb rdy = valid && r0 && r1;

    // R9: a write never lands on an occupied slot, so nothing is displaced.
    assert_write_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid);

    // R7: issue only frees a slot that was ready, and the slot is empty afterwards.
    assert_issue_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_clr |-> (valid && r0 && r1) ##1 !valid);

    // R6: a matching broadcast to a waiting slot makes that operand ready.
    assert_wake_src0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wr_en && !iss_clr && wb_valid && wb_tag == s0) |=> r0);
    assert_wake_src1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wr_en && !iss_clr && wb_valid && wb_tag == s1) |=> r1);

endmodule

// File: rtl/viq_top.sv
// Module: viq_top
// Variation-aware, non-collapsing issue queue. Dispatch is steered to
// fast slots first. A write into a slow slot is finished one cycle later,
// and dispatch stalls during that extra cycle. A tag broadcast wakes
// operands, and one ready instruction issues per cycle, lowest index first.
// Assumes: the slow vector comes from characterisation and only changes
// through cfg_load. There is no back-pressure on the issue output.
module viq_top #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    parameter int OP_W  = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DEPTH-1:0] cfg_slow,
    input  logic             disp_valid,
    input  logic [OP_W-1:0]  disp_op,
    input  logic [TAG_W-1:0] disp_src0,
    input  logic             disp_src0_rdy,
    input  logic [TAG_W-1:0] disp_src1,
    input  logic             disp_src1_rdy,
    input  logic [TAG_W-1:0] disp_dst,
    output logic             disp_stall,
    output logic             q_full,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    output logic             iss_valid,
    output logic [IW-1:0]    iss_idx,
    output logic [OP_W-1:0]  iss_op,
    output logic [TAG_W-1:0] iss_src0,
    output logic [TAG_W-1:0] iss_src1,
    output logic [TAG_W-1:0] iss_dst
);
    import viq_pkg::*;

    logic [DEPTH-1:0] slow_vec;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] rdy_vec;
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] wr_en;
    logic [DEPTH-1:0] grant;
    logic [OP_W-1:0]  e_op  [DEPTH];
    logic [TAG_W-1:0] e_s0  [DEPTH];
    logic [TAG_W-1:0] e_s1  [DEPTH];
    logic [TAG_W-1:0] e_dst [DEPTH];

    logic             alloc_found;
    logic [IW-1:0]    alloc_idx;
    logic             alloc_slow;
    logic             disp_fire;
    logic             fast_fire;
    logic             sel_found;
    logic [IW-1:0]    sel_idx;

    wr_state_e        wr_state;
    logic             pend_valid;
    logic [IW-1:0]    p_idx;
    logic [OP_W-1:0]  p_op;
    logic [TAG_W-1:0] p_s0;
    logic             p_r0;
    logic [TAG_W-1:0] p_s1;
    logic             p_r1;
    logic [TAG_W-1:0] p_dst;

    logic             byp_r0;
    logic             byp_r1;
    logic [OP_W-1:0]  w_op;
    logic [TAG_W-1:0] w_s0;
    logic             w_r0;
    logic [TAG_W-1:0] w_s1;
    logic             w_r1;
    logic [TAG_W-1:0] w_dst;

    // Slow-entry vector: cleared to all-fast at reset, replaced on cfg_load.
    always_ff @(posedge clk) begin
        if (!rst_n)        slow_vec <= '0;
        else if (cfg_load) slow_vec <= cfg_slow;
    end

    // Occupancy, free set, and the dispatch handshake.
    always_comb begin
        free_vec   = ~valid_vec;
        q_full     = &valid_vec;
        pend_valid = (wr_state == WR_SLOW_DONE);
        disp_stall = q_full || pend_valid;
        disp_fire  = disp_valid && !disp_stall && alloc_found;
        fast_fire  = disp_fire && !alloc_slow;
    end

    viq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .free_vec (free_vec),
        .slow_vec (slow_vec),
        .found    (alloc_found),
        .idx      (alloc_idx),
        .is_slow  (alloc_slow)
    );

    // Same-cycle wakeup of the incoming operands.
    always_comb begin
        byp_r0 = disp_src0_rdy || (wb_valid && wb_tag == disp_src0);
        byp_r1 = disp_src1_rdy || (wb_valid && wb_tag == disp_src1);
    end

    // Slow-write sequencer: capture the instruction, then commit it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_state <= WR_IDLE;
            p_idx    <= '0;
            p_op     <= '0;
            p_s0     <= '0;
            p_r0     <= 1'b0;
            p_s1     <= '0;
            p_r1     <= 1'b0;
            p_dst    <= '0;
        end else begin
            case (wr_state)
                WR_IDLE: begin
                    if (disp_fire && alloc_slow) begin
                        wr_state <= WR_SLOW_DONE;
                        p_idx    <= alloc_idx;
                        p_op     <= disp_op;
                        p_s0     <= disp_src0;
                        p_r0     <= byp_r0;
                        p_s1     <= disp_src1;
                        p_r1     <= byp_r1;
                        p_dst    <= disp_dst;
                    end
                end
                default: wr_state <= WR_IDLE;
            endcase
        end
    end

    // Write-data mux: the finishing slow write, or a direct fast write.
    always_comb begin
        if (pend_valid) begin
            w_op  = p_op;
            w_s0  = p_s0;
            w_r0  = p_r0 || (wb_valid && wb_tag == p_s0);
            w_s1  = p_s1;
            w_r1  = p_r1 || (wb_valid && wb_tag == p_s1);
            w_dst = p_dst;
        end else begin
            w_op  = disp_op;
            w_s0  = disp_src0;
            w_r0  = byp_r0;
            w_s1  = disp_src1;
            w_r1  = byp_r1;
            w_dst = disp_dst;
        end
    end

    // Per-slot write enables from the fast path or the slow commit.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wr_en[i] = (fast_fire && alloc_idx == IW'(i)) ||
                       (pend_valid && p_idx == IW'(i));
        end
    end

    // The array of slots. A slot never moves once it is written.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        viq_entry #(.TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_op    (w_op),
            .wr_s0    (w_s0),
            .wr_r0    (w_r0),
            .wr_s1    (w_s1),
            .wr_r1    (w_r1),
            .wr_dst   (w_dst),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .iss_clr  (grant[g]),
            .valid    (valid_vec[g]),
            .rdy      (rdy_vec[g]),
            .op       (e_op[g]),
            .s0       (e_s0[g]),
            .s1       (e_s1[g]),
            .dst      (e_dst[g])
        );
    end

    viq_select #(.DEPTH(DEPTH)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_vec (rdy_vec),
        .found     (sel_found),
        .idx       (sel_idx),
        .grant     (grant)
    );

    // Issue port: read out the selected slot.
    always_comb begin
        iss_valid = sel_found;
        iss_idx   = sel_idx;
        iss_op    = e_op[sel_idx];
        iss_src0  = e_s0[sel_idx];
        iss_src1  = e_s1[sel_idx];
        iss_dst   = e_dst[sel_idx];
    end

    // R3: a slow slot is allocated only when no fast slot is free.
    assert_fast_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && alloc_slow) |-> ((free_vec & ~slow_vec) == '0));

    // R2: a fast allocation lands on a free fast slot.
    assert_fast_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_fire |-> (free_vec[alloc_idx] && !slow_vec[alloc_idx]));

    // R5: a slow write stalls dispatch for exactly one cycle, then commits.
    assert_slow_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && alloc_slow) |=> (disp_stall && pend_valid) ##1 !pend_valid);

    // R8: while the queue is full, no slot write occurs.
    assert_full_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !pend_valid) |-> (wr_en == '0));

endmodule

// File: tb/sim_viq_top.sv
// Bench for viq_top: a scoreboard of expected issues plus direct checks.
module sim_viq_top;
    localparam int DEPTH = 4;
    localparam int TAG_W = 5;
    localparam int OP_W  = 6;
    localparam int IW    = $clog2(DEPTH);
    localparam int SB_W  = IW + OP_W + TAG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [DEPTH-1:0] cfg_slow = '0;
    logic             disp_valid = 1'b0;
    logic [OP_W-1:0]  disp_op = '0;
    logic [TAG_W-1:0] disp_src0 = '0;
    logic             disp_src0_rdy = 1'b0;
    logic [TAG_W-1:0] disp_src1 = '0;
    logic             disp_src1_rdy = 1'b0;
    logic [TAG_W-1:0] disp_dst = '0;
    logic             disp_stall;
    logic             q_full;
    logic             wb_valid = 1'b0;
    logic [TAG_W-1:0] wb_tag = '0;
    logic             iss_valid;
    logic [IW-1:0]    iss_idx;
    logic [OP_W-1:0]  iss_op;
    logic [TAG_W-1:0] iss_src0;
    logic [TAG_W-1:0] iss_src1;
    logic [TAG_W-1:0] iss_dst;

    int checks = 0;
    int errors = 0;
    logic [SB_W-1:0] sb[$];

    viq_top #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) u0 (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_issue(input int idx, input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst);
        sb.push_back({IW'(idx), op, dst});
    endtask

    // Monitor: every issue must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (sb.size() == 0) begin
                check("R7 unexpected issue", {iss_idx, iss_op, iss_dst}, 32'hFFFF_FFFF);
            end else begin
                logic [SB_W-1:0] e;
                e = sb.pop_front();
                check("R2/R3/R7/R9 issue idx,op,dst", {iss_idx, iss_op, iss_dst}, e);
            end
        end
    end

    task automatic set_mask(input logic [DEPTH-1:0] m);
        @(negedge clk);
        cfg_load = 1'b1; cfg_slow = m;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Driver: offer one instruction, optionally with a broadcast in the same cycle.
    task automatic disp(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] s0, input logic r0,
                        input logic [TAG_W-1:0] s1, input logic r1, input logic [TAG_W-1:0] dst,
                        input logic wbv, input logic [TAG_W-1:0] wbt);
        while (disp_stall) @(negedge clk);
        disp_valid = 1'b1; disp_op = op; disp_src0 = s0; disp_src0_rdy = r0;
        disp_src1 = s1; disp_src1_rdy = r1; disp_dst = dst;
        wb_valid = wbv; wb_tag = wbt;
        @(negedge clk);
        disp_valid = 1'b0; wb_valid = 1'b0;
    endtask

    task automatic wake(input logic [TAG_W-1:0] t);
        wb_valid = 1'b1; wb_tag = t;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 iss_valid", iss_valid, 0);
        check("R1 disp_stall", disp_stall, 0);
        check("R1 q_full", q_full, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R2: a fast write of a ready instruction issues from slot 0 in the next cycle.
        expect_issue(0, 6'h11, 5'd1);
        disp(6'h11, 5'd2, 1, 5'd3, 1, 5'd1, 0, 0);
        check("R4 fast ready visible", iss_valid, 1);
        check("R4 no stall", disp_stall, 0);
        idle(2);

        // R10/R2/R3/R5/R8/R9: slow vector 0101, so slots 0 and 2 are slow.
        set_mask(4'b0101);
        disp(6'h21, 5'd10, 0, 5'd0, 1, 5'd21, 0, 0);   // fast slot 1
        check("R2 fast no stall", disp_stall, 0);
        disp(6'h22, 5'd11, 0, 5'd0, 1, 5'd22, 0, 0);   // fast slot 3
        disp(6'h23, 5'd12, 0, 5'd0, 1, 5'd23, 0, 0);   // R3: slow slot 0
        check("R5 stall in slow cycle", disp_stall, 1);
        @(negedge clk);
        check("R5 stall is one cycle", disp_stall, 0);
        disp(6'h24, 5'd13, 0, 5'd0, 1, 5'd24, 0, 0);   // R3: slow slot 2
        @(negedge clk);
        check("R8 q_full", q_full, 1);
        check("R8 stall when full", disp_stall, 1);
        // R8: a request offered while full must not be accepted (no extra issue appears).
        disp_valid = 1'b1; disp_op = 6'h3F; disp_src0_rdy = 1'b1; disp_src1_rdy = 1'b1;
        idle(2);
        disp_valid = 1'b0;
        check("R8 still full", q_full, 1);
        // R9: wake in an order unlike allocation order; indices stay fixed.
        expect_issue(0, 6'h23, 5'd23); wake(5'd12); idle(1);
        expect_issue(2, 6'h24, 5'd24); wake(5'd13); idle(1);
        expect_issue(1, 6'h21, 5'd21); wake(5'd10); idle(1);
        expect_issue(3, 6'h22, 5'd22); wake(5'd11); idle(2);
        check("R8 drained", q_full, 0);

        // R7: one shared wakeup makes all four ready; issue runs 0,1,2,3.
        set_mask(4'b0000);
        for (int i = 0; i < DEPTH; i++) disp(6'(8'h30 + i), 5'd20, 0, 5'd0, 1, 5'(i + 1), 0, 0);
        for (int i = 0; i < DEPTH; i++) expect_issue(i, 6'(8'h30 + i), 5'(i + 1));
        wake(5'd20);
        idle(DEPTH + 1);

        // R6: a broadcast in the dispatch cycle marks the new operand ready.
        expect_issue(0, 6'h2A, 5'd7);
        disp(6'h2A, 5'd25, 0, 5'd0, 1, 5'd7, 1, 5'd25);
        check("R6 same-cycle wake", iss_valid, 1);
        idle(2);

        // R5: a slow ready write becomes visible one cycle later than a fast one.
        set_mask(4'b1111);
        expect_issue(0, 6'h2B, 5'd8);
        disp(6'h2B, 5'd2, 1, 5'd3, 1, 5'd8, 0, 0);
        check("R5 slow not yet visible", iss_valid, 0);
        @(negedge clk);
        check("R5 slow visible", iss_valid, 1);
        idle(2);

        // R6: a broadcast during the extra slow-write cycle is not lost.
        expect_issue(0, 6'h2C, 5'd9);
        disp(6'h2C, 5'd26, 0, 5'd0, 1, 5'd9, 0, 0);
        wake(5'd26);
        check("R6 wake in slow cycle", iss_valid, 1);
        idle(3);

        check("R7 scoreboard empty", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule